// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit is a bus slave that puts a single-bit view of memory in front of an ordinary byte-lane memory port. A 32 MB alias window is decoded ahead of the unit. Each 32-bit word of that window stands for exactly one bit of a 1 MB target region that starts at a configurable base. A read from the alias returns the chosen bit as 0 or 1. A write to the alias sets or clears that bit with a locked read-modify-write on the memory port. Every other bit of the memory unit keeps its value.

The size of the slave access picks the memory unit that is touched. The unit can be a byte, a halfword or a word, and the bit index is taken modulo the width of that unit. Memory data is little-endian, so bit n of a halfword or word lies in byte lane n/8 of the unit. A system uses two copies of the unit that differ only in their target base: one targets 0x20000000 behind the alias at 0x22000000, and the other targets 0x40000000 behind the alias at 0x42000000.

The slave port accepts one request when `s_valid` and `s_ready` are both high. It then returns a single response pulse. The memory port holds `m_req` until `m_ack`, and read data is valid in the `m_ack` cycle.

Top module: `bitband_alias_unit`

## Requirements
- R1: The target address is TARGET_BASE ORed with bits [24:0] of the slave offset shifted right by 5. Offset bits 25 and above have no effect.
- R2: A byte access (`s_size`=0) uses bit index offset[4:2] within the target byte. It drives `m_addr` with the target byte address and enables the single lane addr[1:0] on `m_be` (bit k of `m_be` enables data bits 8k+7..8k).
- R3: A halfword access (`s_size`=1) clears target address bit 0 and uses bit index offset[5:2]. It enables lanes 1:0 when address bit 1 is 0, and lanes 3:2 otherwise.
- R4: A word access (`s_size`=2 or 3) clears target address bits 1:0, uses bit index offset[6:2] and enables all four lanes.
- R5: A read response carries the selected memory bit in `s_rdata[0]`, with `s_rdata[31:1]` zero.
- R6: A write (`s_write`=1) stores `s_wdata[0]` into the selected bit. All other bits of the unit are written back unchanged. The write response data is zero.
- R7: A write issues exactly one memory read and then, in the very next cycle, one memory write to the same address and lanes. A read issues exactly one memory read. `s_ready` stays low from acceptance until the response has been given.
- R8: `s_rsp_valid` is a one-cycle pulse. It comes in the cycle after the last memory `m_ack`, and `m_req` is low while it is high.
- R9: Once raised, `m_req` stays high with a stable `m_addr`, `m_be` and `m_we` until `m_ack`.
- R10: During and after reset the unit is idle: `s_ready` is 1, and `m_req` and `s_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Slave request valid |
| s_ready | output | 1 | Slave can accept a request |
| s_addr | input | 32 | Byte offset into the alias window |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| s_write | input | 1 | 1 = write, 0 = read |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_rsp_valid | output | 1 | Response pulse |
| s_rdata | output | 32 | Response data |
| m_req | output | 1 | Memory transfer request |
| m_we | output | 1 | Memory transfer is a write |
| m_addr | output | 32 | Aligned byte address of the memory unit |
| m_be | output | 4 | Byte-lane enables |
| m_wdata | output | 32 | Memory write data, on the addressed lanes |
| m_ack | input | 1 | Memory transfer complete |
| m_rdata | input | 32 | Memory read data, valid with m_ack |

## Verification
The assertions check the memory handshake on every cycle: the request is held with a stable address and lanes until `m_ack`, and the write of a pair follows its read directly. They also check that the response is a one-cycle pulse right after the final acknowledge, with only bit 0 of the read data able to be set, and that every request keeps the base bits. Only the bench scenarios can show that the right bit of the right unit is read or changed for each size. They cover the masking of high offset bits, the extreme bit indices 7, 15 and 31, and the last offset of the window. They also show that neighbouring bits survive a write, which the bench compares against its own shadow of memory while the acknowledge latency varies.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_DATA_W = 32;
    localparam int BB_LANES  = BB_DATA_W / 8;
    localparam int BB_POS_W  = $clog2(BB_DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MEM_RD = 2'd1,
        ST_MEM_WR = 2'd2,
        ST_RESP   = 2'd3
    } bb_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } bb_size_e;

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bb_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              WIN_BITS    = 25,
    parameter int              BIT_SHIFT   = 5,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0]   offset,
    input  logic [1:0]          size,
    output logic [ADDR_W-1:0]   unit_addr,
    output logic [BB_LANES-1:0] lane_en,
    output logic [BB_POS_W-1:0] bit_pos
);

    localparam int IDX_LSB = 2;

    logic [ADDR_W-1:0]   win_off;
    logic [ADDR_W-1:0]   tgt;
    logic [BB_POS_W-1:0] idx;

    always_comb begin
        win_off = '0;
        win_off[WIN_BITS-1:0] = offset[WIN_BITS-1:0];
        tgt = TARGET_BASE | (win_off >> BIT_SHIFT);
        idx = offset[IDX_LSB +: BB_POS_W];

        case (bb_size_e'(size))
            SZ_BYTE: begin
                unit_addr = tgt;
                lane_en   = BB_LANES'(1) << tgt[1:0];
                bit_pos   = {tgt[1:0], idx[2:0]};
            end
            SZ_HALF: begin
                unit_addr = {tgt[ADDR_W-1:1], 1'b0};
                lane_en   = tgt[1] ? 4'b1100 : 4'b0011;
                bit_pos   = {tgt[1], idx[3:0]};
            end
            default: begin
                unit_addr = {tgt[ADDR_W-1:2], 2'b00};
                lane_en   = '1;
                bit_pos   = idx;
            end
        endcase
    end

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
    import bb_pkg::*;
(
    input  logic [BB_DATA_W-1:0] word_in,
    input  logic [BB_POS_W-1:0]  bit_pos,
    input  logic                 new_bit,
    output logic                 bit_out,
    output logic [BB_DATA_W-1:0] merged
);

    logic [BB_DATA_W-1:0] sel;

    always_comb begin
        sel     = BB_DATA_W'(1) << bit_pos;
        bit_out = |(word_in & sel);
        merged  = new_bit ? (word_in | sel) : (word_in & ~sel);
    end

endmodule

// File: rtl/bitband_alias_unit.sv
module bitband_alias_unit
    import bb_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                WIN_BITS    = 25,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h2000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [ADDR_W-1:0]    s_addr,
    input  logic [1:0]           s_size,
    input  logic                 s_write,
    input  logic [BB_DATA_W-1:0] s_wdata,
    output logic                 s_rsp_valid,
    output logic [BB_DATA_W-1:0] s_rdata,
    output logic                 m_req,
    output logic                 m_we,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [BB_LANES-1:0]  m_be,
    output logic [BB_DATA_W-1:0] m_wdata,
    input  logic                 m_ack,
    input  logic [BB_DATA_W-1:0] m_rdata
);

    typedef struct packed {
        bb_state_e            st;
        logic [ADDR_W-1:0]    addr;
        logic [BB_LANES-1:0]  be;
        logic [BB_POS_W-1:0]  pos;
        logic                 wr;
        logic                 wbit;
        logic [BB_DATA_W-1:0] word;
        logic [BB_DATA_W-1:0] rsp;
    } bb_regs_t;

    bb_regs_t r_d, r_q;

    logic [ADDR_W-1:0]    map_addr;
    logic [BB_LANES-1:0]  map_be;
    logic [BB_POS_W-1:0]  map_pos;
    logic                 rd_bit;
    logic [BB_DATA_W-1:0] rd_merged;

    bb_addr_map #(
        .ADDR_W      (ADDR_W),
        .WIN_BITS    (WIN_BITS),
        .BIT_SHIFT   (5),
        .TARGET_BASE (TARGET_BASE)
    ) u_map (
        .offset    (s_addr),
        .size      (s_size),
        .unit_addr (map_addr),
        .lane_en   (map_be),
        .bit_pos   (map_pos)
    );

    bb_bit_lane u_lane (
        .word_in (m_rdata),
        .bit_pos (r_q.pos),
        .new_bit (r_q.wbit),
        .bit_out (rd_bit),
        .merged  (rd_merged)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (s_valid) begin
                    r_d.addr = map_addr;
                    r_d.be   = map_be;
                    r_d.pos  = map_pos;
                    r_d.wr   = s_write;
                    r_d.wbit = s_wdata[0];
                    r_d.st   = ST_MEM_RD;
                end
            end
            ST_MEM_RD: begin
                if (m_ack) begin
                    if (r_q.wr) begin
                        r_d.word = rd_merged;
                        r_d.st   = ST_MEM_WR;
                    end else begin
                        r_d.rsp  = {{(BB_DATA_W-1){1'b0}}, rd_bit};
                        r_d.st   = ST_RESP;
                    end
                end
            end
            ST_MEM_WR: begin
                if (m_ack) begin
                    r_d.rsp = '0;
                    r_d.st  = ST_RESP;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign s_ready     = (r_q.st == ST_IDLE);
    assign s_rsp_valid = (r_q.st == ST_RESP);
    assign s_rdata     = r_q.rsp;
    assign m_req       = (r_q.st == ST_MEM_RD) || (r_q.st == ST_MEM_WR);
    assign m_we        = (r_q.st == ST_MEM_WR);
    assign m_addr      = r_q.addr;
    assign m_be        = r_q.be;
    assign m_wdata     = m_we ? r_q.word : '0;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_be) && $stable(m_we));

    // R7
    rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && !$past(m_we)) |-> ($past(m_ack) && $past(m_req) && $stable(m_addr) && $stable(m_be)));

    // R7
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready |=> !s_ready);

    // R8
    rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |-> $past(m_ack) && !m_req);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |=> !s_rsp_valid);

    // R5
    rdata_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |-> (s_rdata[BB_DATA_W-1:1] == '0));

    // R1
    base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((m_addr & TARGET_BASE) == TARGET_BASE));

endmodule

// File: tb/bitband_alias_unit_tb.sv
module bitband_alias_unit_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic        s_write = 1'b0;
    logic [31:0] s_wdata = '0;
    logic        s_rsp_valid;
    logic [31:0] s_rdata;
    logic        m_req;
    logic        m_we;
    logic [31:0] m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wdata;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] memb [0:4095];
    logic [7:0] shb  [0:4095];

    logic [31:0] exp_ua;
    logic [3:0]  exp_be;
    bit          in_acc = 0;
    bit          busy = 0;
    int          acks = 0;
    int          lat_cnt = 0;
    int          lat_seed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitband_alias_unit #(.TARGET_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_size(s_size),
        .s_write(s_write), .s_wdata(s_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_be(m_be),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: variable acknowledge latency, little-endian byte lanes.
    always @(negedge clk) begin
        if (m_ack) begin
            m_ack   <= 1'b0;
            lat_seed = lat_seed + 1;
            lat_cnt  = lat_seed % 3;
        end else if (m_req) begin
            if (lat_cnt == 0) begin
                for (int k = 0; k < 4; k++) begin
                    if (m_we && m_be[k])
                        memb[{m_addr[11:2], 2'(k)}] = m_wdata[8*k +: 8];
                    m_rdata[8*k +: 8] <= memb[{m_addr[11:2], 2'(k)}];
                end
                m_ack <= 1'b1;
            end else begin
                lat_cnt = lat_cnt - 1;
            end
        end
    end

    always @(posedge clk) if (rst_n && m_ack) acks++;

    // Per-cycle monitor of the memory request and slave ready.
    always @(negedge clk) begin
        if (in_acc && m_req) begin
            check(m_addr == exp_ua, "R1", "m_addr", m_addr, exp_ua);
            check(m_be == exp_be, "R2", "m_be", {28'h0, m_be}, {28'h0, exp_be});
        end
        if (busy)
            check(s_ready == 1'b0, "R7", "s_ready while busy", {31'h0, s_ready}, 32'h0);
    end

    task automatic access(input logic [31:0] off, input int sz, input bit wr,
                          input bit wb, input string req);
        logic [31:0] tgt, ba;
        int n, bt;
        logic exp_bit;
        tgt = BASE | ((off & 32'h01FF_FFFF) >> 5);
        n = int'((off >> 2) & 31);
        if (sz == 0) begin
            exp_ua = tgt; exp_be = 4'b0001 << tgt[1:0]; ba = tgt; bt = n % 8;
        end else if (sz == 1) begin
            exp_ua = tgt & ~32'd1; exp_be = 4'b0011 << exp_ua[1:0];
            ba = exp_ua + 32'((n % 16) / 8); bt = n % 8;
        end else begin
            exp_ua = tgt & ~32'd3; exp_be = 4'hF; ba = exp_ua + 32'(n / 8); bt = n % 8;
        end
        exp_bit = shb[ba[11:0]][bt];
        acks = 0;
        @(negedge clk);
        s_valid = 1; s_addr = off; s_size = 2'(sz); s_write = wr; s_wdata = {31'h7FFF_FFFE, wb};
        in_acc = 1;
        @(posedge clk);
        @(negedge clk);
        s_valid = 0; busy = 1;
        while (!s_rsp_valid) @(negedge clk);
        check(s_rdata == (wr ? 32'h0 : {31'h0, exp_bit}), wr ? "R6" : req, "s_rdata",
              s_rdata, wr ? 32'h0 : {31'h0, exp_bit});
        check(acks == (wr ? 2 : 1), "R7", "memory transfer count", 32'(acks), wr ? 32'd2 : 32'd1);
        @(negedge clk);
        busy = 0; in_acc = 0;
        check(s_rsp_valid == 1'b0, "R8", "response pulse length", {31'h0, s_rsp_valid}, 32'h0);
        if (wr) begin
            shb[ba[11:0]][bt] = wb;
            for (int k = 0; k < 4; k++)
                check(memb[exp_ua[11:0] + 12'(k)] == shb[exp_ua[11:0] + 12'(k)], "R6",
                      "memory byte after write", {24'h0, memb[exp_ua[11:0] + 12'(k)]},
                      {24'h0, shb[exp_ua[11:0] + 12'(k)]});
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            memb[i] = 8'(i * 37) ^ 8'h5A;
            shb[i]  = memb[i];
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(s_ready == 1'b1, "R10", "s_ready in reset", {31'h0, s_ready}, 32'h1);
        check(m_req == 1'b0, "R10", "m_req in reset", {31'h0, m_req}, 32'h0);
        check(s_rsp_valid == 1'b0, "R10", "s_rsp_valid in reset", {31'h0, s_rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(s_ready == 1'b1 && m_req == 1'b0, "R10", "idle after reset",
              {30'h0, s_ready, m_req}, 32'h2);

        // R2 byte reads, all bit indices of a few bytes
        for (int b = 0; b < 8; b++) access(32'h0000_0200 + 32'(b*4), 0, 0, 0, "R2");
        for (int b = 0; b < 8; b++) access(32'h0000_0460 + 32'(b*4), 0, 0, 0, "R2");
        // R3 halfword reads, indices 0..15 on both halves
        for (int b = 0; b < 16; b++) access(32'h0000_0800 + 32'(b*4), 1, 0, 0, "R3");
        for (int b = 0; b < 16; b++) access(32'h0000_0840 + 32'(b*4), 1, 0, 0, "R3");
        // R4 word reads, indices 0..31, and reserved size code 3
        for (int b = 0; b < 32; b++) access(32'h0000_1000 + 32'(b*4), 2, 0, 0, "R4");
        access(32'h0000_10FC, 3, 0, 0, "R4");
        // R1 high offset bits ignored, last offset of window
        access(32'hFE00_0234, 0, 0, 0, "R1");
        access(32'h2200_1040, 2, 0, 0, "R1");
        access(32'h01FF_FFFC, 2, 0, 0, "R1");
        access(32'h01FF_FFFC, 0, 0, 0, "R1");

        // R6 writes: set and clear through every size, then read back
        access(32'h0000_0200, 0, 1, 1, "R6");
        access(32'h0000_021C, 0, 1, 0, "R6");
        access(32'h0000_021C, 0, 0, 0, "R2");
        access(32'h0000_0200, 0, 0, 0, "R2");
        access(32'h0000_087C, 1, 1, 1, "R6");
        access(32'h0000_0840, 1, 1, 0, "R6");
        access(32'h0000_087C, 1, 0, 0, "R3");
        access(32'h0000_10FC, 2, 1, 0, "R6");
        access(32'h0000_10FC, 2, 1, 1, "R6");
        access(32'h0000_1000, 2, 1, 1, "R6");
        access(32'h0000_1044, 2, 1, 0, "R6");
        access(32'h0000_10FC, 2, 0, 0, "R4");
        access(32'h0000_1044, 2, 0, 0, "R4");
        access(32'hFE00_1004, 2, 1, 1, "R1");
        access(32'h0000_1004, 2, 0, 0, "R1");
        access(32'h01FF_FFFC, 2, 1, 0, "R6");
        access(32'h01FF_FFFC, 2, 0, 0, "R4");

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule